// File: doc/BRIEF.md
# Tagged Add/Subtract Unit

This block is the arithmetic slice that a processor core uses for tagged integer arithmetic, the kind that runtimes of dynamically typed languages rely on to keep small integers unboxed in the low bits of a word. It adds or subtracts two 64-bit source values and registers the result together with two condition-code sets: a narrow set taken from the low 32 bits and a wide set taken from all 64 bits.

A word is treated as a tagged small integer only when its two lowest bits are zero. The narrow overflow flag therefore reports a tag overflow. It is raised by an ordinary signed 32-bit overflow, and it is also raised when either source carries a nonzero tag. When the trapping form of the operation is selected, a tag overflow becomes a fault. In that case the faulted operation writes neither the result nor the condition codes, and the core's trap logic takes over. The register file and the trap dispatch sit outside the block.

Each operation takes one clock cycle. The sources and the two selects are sampled at a rising edge, and every output reflects that operation after the edge.

Top module: `tagged_addsub`

## Requirements
- R1: One cycle after the sources are presented, `res_o` holds `src_a_i + src_b_i` (modulo 2^64) when `sub_sel_i` is 0, and `src_a_i - src_b_i` when it is 1.
- R2: `cc_narrow_o` is packed as {N, Z, V, C} in bits 3 down to 0. N is result bit 31. Z is 1 when result bits 31:0 are all zero. On an add, C is the carry out of bit 31; on a subtract, C is the borrow out of bit 31 (1 when the low 32 bits of `src_a_i` are unsigned-less than those of `src_b_i`).
- R3: `cc_wide_o` uses the same {N, Z, V, C} packing. N is result bit 63, Z is 1 when the whole 64-bit result is zero, and C is the carry (on add) or borrow (on subtract) out of bit 63.
- R4: The wide V flag is plain signed 64-bit overflow. On an add it is set when both sources have the same bit 63 and the result's bit 63 differs from it. On a subtract it is set when the sources' bit 63 values differ and the result's bit 63 differs from that of `src_a_i`.
- R5: The narrow V flag is the tag-overflow value. It is 1 when bits 1:0 of `src_a_i` are nonzero, or bits 1:0 of `src_b_i` are nonzero, or the operation overflows as signed 32-bit arithmetic (the bit-31 form of the R4 rule).
- R6: With `trap_en_i` at 0, `fault_o` stays 0 and `commit_o` is 1 after every operation, including operations that overflow.
- R7: With `trap_en_i` at 1 and a tag overflow present, `fault_o` is 1 and `commit_o` is 0 for that operation. `res_o`, `cc_narrow_o` and `cc_wide_o` keep the values of the last committed operation.
- R8: With `trap_en_i` at 1 and no tag overflow, the operation commits exactly as in R6.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand (register or immediate, already selected) |
| sub_sel_i | input | 1 | 0 = add, 1 = subtract |
| trap_en_i | input | 1 | 1 = a tag overflow raises a fault |
| res_o | output | 64 | Last committed result |
| commit_o | output | 1 | The operation of the previous cycle wrote its result and condition codes |
| cc_narrow_o | output | 4 | 32-bit condition codes {N,Z,V,C} |
| cc_wide_o | output | 4 | 64-bit condition codes {N,Z,V,C} |
| fault_o | output | 1 | The operation of the previous cycle raised a tag-overflow fault |

## Verification
The bench drives several boundary cases:
- Sums that overflow at bit 31 but not at bit 63. A design that took the narrow V from the wide overflow would miss these.
- Sums that overflow at bit 63 but not at bit 31. This catches a wide V that was fed from the tag logic.
- Subtractions that borrow. A unit that reported the raw carry instead of the borrow would show C inverted.
- A nonzero tag in either source, with no arithmetic overflow, in both the trapping and the non-trapping form. This exposes a narrow V that ignores tags, and a fault raised without the trap select.
- Back-to-back faulted operations, followed by a clean trapping operation. A design that let a fault write through would show a changed result or changed flags. A design that blocked a clean trapping operation would drop a valid commit.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;

   // Condition-code set, bit 3 down to bit 0: N, Z, V, C
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_t;

   localparam int CC_W = 4;

endpackage

// File: rtl/tagalu_adder.sv
// Two's-complement adder for add/sub, with the carry out of the narrow
// boundary and the carry out of the top bit both exposed.
module tagalu_adder #(
   parameter int DATA_W      = 64,
   parameter int SPLIT_W     = 32,
   parameter bit SPLIT_CHAIN = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_lo_o,
   output logic              cout_hi_o
);
   localparam int HI_W = DATA_W - SPLIT_W;

   initial begin
      assert (SPLIT_W > 0 && SPLIT_W < DATA_W)
         else $error("tagalu_adder: SPLIT_W must lie strictly inside DATA_W");
   end

   logic [DATA_W-1:0] b_eff;
   assign b_eff = sub_i ? ~b_i : b_i;

   if (SPLIT_CHAIN) begin : g_split
      // two chained segments; the low carry comes straight off the low segment
      logic [SPLIT_W:0] lo_sum;
      logic [HI_W:0]    hi_sum;
      assign lo_sum = {1'b0, a_i[SPLIT_W-1:0]} + {1'b0, b_eff[SPLIT_W-1:0]}
                    + {{SPLIT_W{1'b0}}, sub_i};
      assign hi_sum = {1'b0, a_i[DATA_W-1:SPLIT_W]} + {1'b0, b_eff[DATA_W-1:SPLIT_W]}
                    + {{HI_W{1'b0}}, lo_sum[SPLIT_W]};
      assign sum_o     = {hi_sum[HI_W-1:0], lo_sum[SPLIT_W-1:0]};
      assign cout_lo_o = lo_sum[SPLIT_W];
      assign cout_hi_o = hi_sum[HI_W];
   end else begin : g_flat
      // one wide adder; the carry into bit SPLIT_W is recovered from the sum
      logic [DATA_W:0] full_sum;
      assign full_sum  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
      assign sum_o     = full_sum[DATA_W-1:0];
      assign cout_lo_o = full_sum[SPLIT_W] ^ a_i[SPLIT_W] ^ b_eff[SPLIT_W];
      assign cout_hi_o = full_sum[DATA_W];
   end

endmodule

// File: rtl/tagalu_flags.sv
// N, Z, C and plain signed overflow for one slice of the result.
module tagalu_flags #(
   parameter int W = 32
) (
   input  logic [W-1:0] r_i,
   input  logic         a_msb_i,
   input  logic         b_msb_i,
   input  logic         cout_raw_i,
   input  logic         sub_i,
   output logic         n_o,
   output logic         z_o,
   output logic         c_o,
   output logic         ovf_o
);
   initial begin
      assert (W >= 2) else $error("tagalu_flags: W too small");
   end

   logic r_msb;
   assign r_msb = r_i[W-1];

   assign n_o = r_msb;
   assign z_o = (r_i == '0);
   // a subtract reports a borrow, which is the inverted adder carry
   assign c_o = sub_i ? ~cout_raw_i : cout_raw_i;

   always_comb begin
      if (sub_i) ovf_o = (a_msb_i != b_msb_i) && (r_msb != a_msb_i);
      else       ovf_o = (a_msb_i == b_msb_i) && (r_msb != a_msb_i);
   end

endmodule

// File: rtl/tagalu_tagchk.sv
// Tag check: merges low-bit tags with narrow signed overflow, and forms the fault.
module tagalu_tagchk #(
   parameter int TAG_W   = 2,
   parameter bit TRAP_EN = 1'b1
) (
   input  logic [TAG_W-1:0] a_tag_i,
   input  logic [TAG_W-1:0] b_tag_i,
   input  logic             ovf_i,
   input  logic             trap_sel_i,
   output logic             tag_ovf_o,
   output logic             fault_o
);
   initial begin
      assert (TAG_W >= 1) else $error("tagalu_tagchk: TAG_W must be positive");
   end

   logic tag_nz;
   assign tag_nz    = (a_tag_i != '0) || (b_tag_i != '0);
   assign tag_ovf_o = tag_nz || ovf_i;
   assign fault_o   = TRAP_EN && trap_sel_i && tag_ovf_o;

endmodule

// File: rtl/tagged_addsub.sv
module tagged_addsub
   import tagalu_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int NARROW_W    = 32,
   parameter int TAG_W       = 2,
   parameter bit SPLIT_CHAIN = 1'b1,
   parameter bit TRAP_EN     = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic              sub_sel_i,
   input  logic              trap_en_i,
   output logic [DATA_W-1:0] res_o,
   output logic              commit_o,
   output logic [CC_W-1:0]   cc_narrow_o,
   output logic [CC_W-1:0]   cc_wide_o,
   output logic              fault_o
);
   initial begin
      assert (NARROW_W > TAG_W && NARROW_W < DATA_W)
         else $error("tagged_addsub: need TAG_W < NARROW_W < DATA_W");
   end

   // ---------------- datapath ----------------
   logic [DATA_W-1:0] sum;
   logic              cout_lo, cout_hi;

   tagalu_adder #(
      .DATA_W(DATA_W), .SPLIT_W(NARROW_W), .SPLIT_CHAIN(SPLIT_CHAIN)
   ) adder_i (
      .a_i(src_a_i), .b_i(src_b_i), .sub_i(sub_sel_i),
      .sum_o(sum), .cout_lo_o(cout_lo), .cout_hi_o(cout_hi)
   );

   logic n_lo, z_lo, c_lo, ovf_lo;
   logic n_hi, z_hi, c_hi, ovf_hi;

   tagalu_flags #(.W(NARROW_W)) flags_lo_i (
      .r_i(sum[NARROW_W-1:0]),
      .a_msb_i(src_a_i[NARROW_W-1]), .b_msb_i(src_b_i[NARROW_W-1]),
      .cout_raw_i(cout_lo), .sub_i(sub_sel_i),
      .n_o(n_lo), .z_o(z_lo), .c_o(c_lo), .ovf_o(ovf_lo)
   );

   tagalu_flags #(.W(DATA_W)) flags_hi_i (
      .r_i(sum),
      .a_msb_i(src_a_i[DATA_W-1]), .b_msb_i(src_b_i[DATA_W-1]),
      .cout_raw_i(cout_hi), .sub_i(sub_sel_i),
      .n_o(n_hi), .z_o(z_hi), .c_o(c_hi), .ovf_o(ovf_hi)
   );

   logic tag_ovf, fault_d;

   tagalu_tagchk #(.TAG_W(TAG_W), .TRAP_EN(TRAP_EN)) tagchk_i (
      .a_tag_i(src_a_i[TAG_W-1:0]), .b_tag_i(src_b_i[TAG_W-1:0]),
      .ovf_i(ovf_lo), .trap_sel_i(trap_en_i),
      .tag_ovf_o(tag_ovf), .fault_o(fault_d)
   );

   cc_t cc_lo_d, cc_hi_d;
   always_comb begin
      cc_lo_d = '{n: n_lo, z: z_lo, v: tag_ovf, c: c_lo};
      cc_hi_d = '{n: n_hi, z: z_hi, v: ovf_hi,  c: c_hi};
   end

   // ---------------- result stage ----------------
   logic [DATA_W-1:0] res_q;
   cc_t               cc_lo_q, cc_hi_q;
   logic              commit_q, fault_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_q    <= '0;
         cc_lo_q  <= '0;
         cc_hi_q  <= '0;
         commit_q <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         commit_q <= !fault_d;
         fault_q  <= fault_d;
         if (!fault_d) begin
            res_q   <= sum;
            cc_lo_q <= cc_lo_d;
            cc_hi_q <= cc_hi_d;
         end
      end
   end

   assign res_o       = res_q;
   assign commit_o    = commit_q;
   assign cc_narrow_o = cc_lo_q;
   assign cc_wide_o   = cc_hi_q;
   assign fault_o     = fault_q;

   // ---------------- assertions ----------------
   logic started_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) started_q <= 1'b0;
      else         started_q <= 1'b1;
   end

   AST_RESULT_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started_q && commit_q |->
         res_q == ($past(sub_sel_i) ? $past(src_a_i) - $past(src_b_i)
                                    : $past(src_a_i) + $past(src_b_i))); // R1

   AST_WIDE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_q |-> (cc_hi_q.z == (res_q == '0))); // R3

   AST_TAG_SETS_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started_q && commit_q && $past(src_a_i[TAG_W-1:0] != '0 || src_b_i[TAG_W-1:0] != '0)
         |-> cc_lo_q.v); // R5

   AST_NOTRAP_COMMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started_q && !$past(trap_en_i) |-> commit_q && !fault_q); // R6

   AST_FAULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_q |-> !commit_q && $stable(res_q) && $stable(cc_lo_q) && $stable(cc_hi_q)); // R7

endmodule

// File: tb/tagged_addsub_tb_top.sv
`timescale 1ns/1ps
module tagged_addsub_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] a = '0, b = '0;
   logic        sub = 1'b0, trap = 1'b0;
   logic [63:0] res;
   logic        commit, fault;
   logic [3:0]  ccn, ccw;

   always #4 clk = ~clk;   // 125 MHz

   tagged_addsub dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .src_a_i(a), .src_b_i(b), .sub_sel_i(sub), .trap_en_i(trap),
      .res_o(res), .commit_o(commit), .cc_narrow_o(ccn), .cc_wide_o(ccw),
      .fault_o(fault)
   );

   int total = 0, fails = 0;
   bit done = 1'b0;

   // expected state of the committed outputs
   logic [63:0] e_res = '0;
   logic [3:0]  e_ccn = '0, e_ccw = '0;

   // {a, b, sub, trap}
   localparam int NV = 12;
   localparam logic [129:0] VEC [NV] = '{
      {64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 1'b0, 1'b0},
      {64'h0000_0000_7FFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
      {64'hFFFF_FFFF_FFFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
      {64'h0000_0000_0000_0008, 64'h0000_0000_0000_0008, 1'b1, 1'b0},
      {64'h0000_0000_0000_0004, 64'h0000_0000_0000_0008, 1'b1, 1'b0},
      {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
      {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0004, 1'b0, 1'b1},
      {64'h0000_0000_0000_0040, 64'h0000_0000_0000_0002, 1'b1, 1'b1},
      {64'h7FFF_FFFF_FFFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b0},
      {64'h8000_0000_0000_0000, 64'h0000_0000_0000_0004, 1'b1, 1'b0},
      {64'h0000_0000_0000_0100, 64'h0000_0000_0000_0200, 1'b0, 1'b1},
      {64'h0000_0000_8000_0000, 64'h0000_0000_0000_0004, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference model written from the requirements
   task automatic model(input logic [63:0] ma, input logic [63:0] mb, input logic ms,
                        output logic [63:0] r, output logic [3:0] cn,
                        output logic [3:0] cw, output logic tov);
      logic [32:0] n33;
      logic [64:0] w65;
      logic signed [32:0] s33;
      logic signed [64:0] s65;
      logic v32, v64;
      r   = ms ? ma - mb : ma + mb;
      n33 = ms ? {1'b0, ma[31:0]} - {1'b0, mb[31:0]} : {1'b0, ma[31:0]} + {1'b0, mb[31:0]};
      w65 = ms ? {1'b0, ma} - {1'b0, mb} : {1'b0, ma} + {1'b0, mb};
      s33 = ms ? $signed({ma[31], ma[31:0]}) - $signed({mb[31], mb[31:0]})
               : $signed({ma[31], ma[31:0]}) + $signed({mb[31], mb[31:0]});
      s65 = ms ? $signed({ma[63], ma}) - $signed({mb[63], mb})
               : $signed({ma[63], ma}) + $signed({mb[63], mb});
      v32 = s33[32] ^ s33[31];
      v64 = s65[64] ^ s65[63];
      tov = (ma[1:0] != 2'b00) || (mb[1:0] != 2'b00) || v32;
      cn  = {r[31], r[31:0] == 32'h0, tov, n33[32]};
      cw  = {r[63], r == 64'h0, v64, w65[64]};
   endtask

   task automatic run_op(input logic [63:0] va, input logic [63:0] vb,
                         input logic vs, input logic vt);
      logic [63:0] r;
      logic [3:0]  cn, cw;
      logic        tov, f;
      string       rq;
      a = va; b = vb; sub = vs; trap = vt;
      model(va, vb, vs, r, cn, cw, tov);
      f = vt && tov;
      if (!f) begin e_res = r; e_ccn = cn; e_ccw = cw; end
      @(negedge clk);
      rq = f ? "R7" : "R1";
      chk(rq, "result", res, e_res);
      rq = f ? "R7" : "R2/R5";
      chk(rq, "narrow cc", {60'h0, ccn}, {60'h0, e_ccn});
      rq = f ? "R7" : "R3/R4";
      chk(rq, "wide cc", {60'h0, ccw}, {60'h0, e_ccw});
      rq = f ? "R7" : (vt ? "R8" : "R6");
      chk(rq, "commit", {63'h0, commit}, {63'h0, !f});
      chk(rq, "fault", {63'h0, fault}, {63'h0, f});
   endtask

   task automatic chk_reset(input string tag);
      chk("R9", {tag, " result"}, res, 64'h0);
      chk("R9", {tag, " narrow cc"}, {60'h0, ccn}, 64'h0);
      chk("R9", {tag, " wide cc"}, {60'h0, ccw}, 64'h0);
      chk("R9", {tag, " commit"}, {63'h0, commit}, 64'h0);
      chk("R9", {tag, " fault"}, {63'h0, fault}, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_reset("initial");
      rst_n = 1'b1;

      // table walk: R1..R8
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][129:66], VEC[i][65:2], VEC[i][1], VEC[i][0]);
      end

      // R7: two faults in a row keep the last commit, then a clean trapping op commits (R8)
      run_op(64'h0000_0000_0000_1000, 64'h0000_0000_0000_0004, 1'b0, 1'b0);
      run_op(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0000, 1'b0, 1'b1);
      run_op(64'h0000_0000_7FFF_FFFC, 64'h0000_0000_0000_0004, 1'b0, 1'b1);
      run_op(64'h0000_0000_0000_0004, 64'h0000_0000_0000_0004, 1'b1, 1'b1);

      // R5 with a tag only on the second source and no trap: V set, commit
      run_op(64'h0000_0000_0000_0010, 64'h0000_0000_0000_0003, 1'b0, 1'b0);

      // R9: reset in mid-run clears everything
      a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h1; sub = 1'b0; trap = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk_reset("mid-run");
      e_res = '0; e_ccn = '0; e_ccw = '0;
      rst_n = 1'b1;
      run_op(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule